// File: doc/BRIEF.md
# Two-Lane Ones Residue Tracker

The block watches two serial bit lanes and keeps a running total of how many ones have appeared on them since the last reset. Each rising clock edge adds 0, 1 or 2 to that total, depending on how many of the two lanes are high in that cycle. Only the total modulo four is stored. The single output tells the surrounding logic whether the count of ones so far is an exact multiple of four.

The residue is held in a two-bit register in reflected binary (Gray) order. Residues 0, 1, 2 and 3 are stored as 00, 01, 11 and 10. The output is decoded from the register alone, so it is a Moore output and does not change during a cycle. A small control stage counts the high lanes and hands the step size to the datapath as a strobe struct. The datapath turns that step into the next Gray code.

Top module: `ones_mod4_tracker`

## Requirements
- R1: While `rst` is high at a rising edge, the residue is cleared to 0, so `multipleOfFour` reads 1 in the cycle after reset.
- R2: A rising edge with `bitA` = 0 and `bitB` = 0 leaves the residue unchanged, so `multipleOfFour` keeps its value.
- R3: A rising edge with exactly one of `bitA` and `bitB` high advances the residue by one, modulo 4.
- R4: A rising edge with `bitA` = 1 and `bitB` = 1 advances the residue by two, modulo 4. For example, residue 0 goes to 2 and residue 3 goes to 1.
- R5: `multipleOfFour` is 1 exactly when the total number of ones seen on both lanes since reset is divisible by four. It depends only on the stored residue.
- R6: Reset takes priority over the lanes: ones present in a reset cycle are not counted.
- R7: The residue wraps from 3 to 0 on a single step and from 3 to 1 on a double step, with no overflow effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to residue 0 |
| bitA | input | 1 | First serial lane; a 1 adds one to the count |
| bitB | input | 1 | Second serial lane; a 1 adds one to the count |
| multipleOfFour | output | 1 | High when the ones counted since reset total a multiple of four |

## Verification
Idle stretches with both lanes low show that holding is kept separate from stepping. Runs with only `bitA` high and runs with only `bitB` high show that both lanes count with equal weight. Runs with both lanes high, started from each residue, show that a double step differs from a single step and that the wrap from 3 lands on 1. A pseudo-random lane sequence and a reset asserted while both lanes are high show that the residue tracks long mixed histories and that reset discards the ones present in its own cycle.

// File: rtl/onesmod_pkg.sv
package onesmod_pkg;

  // number of serial lanes summed each cycle
  localparam int unsigned LANE_COUNT = 2;
  // residue register width; residue is kept modulo 2**RES_BITS
  localparam int unsigned RES_BITS   = 2;
  // width needed to hold a per-cycle count of 0..LANE_COUNT
  localparam int unsigned CNT_BITS   = $clog2(LANE_COUNT + 1);

  typedef logic [RES_BITS-1:0] resCode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic                hold;       // no lane high this cycle
    logic [CNT_BITS-1:0] stepCount;  // number of high lanes
  } stepCtl_t;

  function automatic resCode_t binToGray(input resCode_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic resCode_t grayToBin(input resCode_t g);
    resCode_t b;
    b[RES_BITS-1] = g[RES_BITS-1];
    for (int i = int'(RES_BITS) - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/ones_step_ctrl.sv
module ones_step_ctrl
  import onesmod_pkg::*;
(
  input  logic [LANE_COUNT-1:0] laneBits,
  output stepCtl_t              ctl
);

  logic [CNT_BITS-1:0] highCount;

  always_comb begin
    highCount = '0;
    for (int i = 0; i < int'(LANE_COUNT); i++) begin
      highCount = highCount + CNT_BITS'(laneBits[i]);
    end
  end

  always_comb begin
    ctl.stepCount = highCount;
    ctl.hold      = (highCount == '0);
  end

endmodule

// File: rtl/ones_residue_dp.sv
module ones_residue_dp
  import onesmod_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  stepCtl_t ctl,
  output logic     zeroFlag
);

  resCode_t stateQ;
  resCode_t stateD;
  resCode_t residueNow;
  resCode_t residueNext;

  always_comb begin
    residueNow  = grayToBin(stateQ);
    residueNext = residueNow + RES_BITS'(ctl.stepCount);
    if (ctl.hold) stateD = stateQ;
    else          stateD = binToGray(residueNext);
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= '0;
    else     stateQ <= stateD;
  end

  assign zeroFlag = ~|stateQ;

  // checker support: marks that a reset has been seen
  logic seenRst;
  always_ff @(posedge clk) begin
    if (rst)           seenRst <= 1'b1;
    else if (!seenRst) seenRst <= 1'b0;
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (seenRst && $past(rst)) |-> (stateQ == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (seenRst && !$past(rst) && $past(ctl.stepCount) == '0) |-> $stable(stateQ));

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    (seenRst && !$past(rst) && $past(ctl.stepCount) == CNT_BITS'(1))
      |-> ($countones(stateQ ^ $past(stateQ)) == 1));

  // R4
  double_step_chk: assert property (@(posedge clk) disable iff (rst)
    (seenRst && !$past(rst) && $past(ctl.stepCount) == CNT_BITS'(2))
      |-> (grayToBin(stateQ) == resCode_t'(grayToBin($past(stateQ)) + 2'd2)));

endmodule

// File: rtl/ones_mod4_tracker.sv
module ones_mod4_tracker
  import onesmod_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bitA,
  input  logic bitB,
  output logic multipleOfFour
);

  stepCtl_t stepCtl;

  ones_step_ctrl ctrl_i (
    .laneBits ({bitB, bitA}),
    .ctl      (stepCtl)
  );

  ones_residue_dp dp_i (
    .clk      (clk),
    .rst      (rst),
    .ctl      (stepCtl),
    .zeroFlag (multipleOfFour)
  );

endmodule

// File: tb/ones_mod4_tracker_tb.sv
module ones_mod4_tracker_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bitA = 1'b0;
  logic bitB = 1'b0;
  logic multipleOfFour;

  int checks = 0;
  int failures = 0;
  int total = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  ones_mod4_tracker dut_i (
    .clk            (clk),
    .rst            (rst),
    .bitA           (bitA),
    .bitB           (bitB),
    .multipleOfFour (multipleOfFour)
  );

  // one cycle: drive at a falling edge, compare at the next falling edge
  task automatic stepCheck(input bit a, input bit b, input bit r, input string tag);
    bit expd;
    rst  = r;
    bitA = a;
    bitB = b;
    @(negedge clk);
    if (r) total = 0;
    else   total = total + int'(a) + int'(b);
    expd = ((total % 4) == 0);
    checks++;
    if (multipleOfFour !== expd) begin
      failures++;
      $display("FAIL %s: count=%0d multipleOfFour=%b expected=%b", tag, total, multipleOfFour, expd);
    end
  endtask

  initial begin
    int waitCycles = 0;
    while (!done && waitCycles < 20000) begin
      @(posedge clk);
      waitCycles++;
    end
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr = 8'hA5;
    @(negedge clk);
    // R1: reset state
    stepCheck(1'b0, 1'b0, 1'b1, "R1");
    stepCheck(1'b0, 1'b0, 1'b1, "R1");
    // R2: idle holds at residue 0
    for (int i = 0; i < 3; i++) stepCheck(1'b0, 1'b0, 1'b0, "R2");
    // R3: lane A alone, through a full wrap (R7)
    stepCheck(1'b1, 1'b0, 1'b0, "R3");
    stepCheck(1'b0, 1'b0, 1'b0, "R2");
    stepCheck(1'b1, 1'b0, 1'b0, "R3");
    stepCheck(1'b1, 1'b0, 1'b0, "R3");
    stepCheck(1'b1, 1'b0, 1'b0, "R7");
    // R3: lane B alone
    for (int i = 0; i < 5; i++) stepCheck(1'b0, 1'b1, 1'b0, "R3");
    // R4: double steps from residue 1
    for (int i = 0; i < 4; i++) stepCheck(1'b1, 1'b1, 1'b0, "R4");
    // move to residue 3, then double-step wrap to 1 (R7)
    stepCheck(1'b0, 1'b1, 1'b0, "R3");
    stepCheck(1'b0, 1'b1, 1'b0, "R3");
    stepCheck(1'b1, 1'b1, 1'b0, "R7");
    stepCheck(1'b0, 1'b0, 1'b0, "R2");
    stepCheck(1'b1, 1'b1, 1'b0, "R4");
    stepCheck(1'b1, 1'b0, 1'b0, "R7");
    // R5: pseudo-random mixed history
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      stepCheck(lfsr[0], lfsr[3], 1'b0, "R5");
    end
    // R6: reset with both lanes high discards those ones
    stepCheck(1'b1, 1'b0, 1'b0, "R5");
    stepCheck(1'b1, 1'b1, 1'b1, "R6");
    stepCheck(1'b0, 1'b0, 1'b0, "R6");
    stepCheck(1'b1, 1'b1, 1'b0, "R4");
    stepCheck(1'b1, 1'b1, 1'b0, "R4");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule